// File: doc/BRIEF.md
# Programmable Decision-Lattice Logic Fabric

This block models a reconfigurable combinational fabric built as a diamond lattice of decision nodes. The lattice has one row per input variable, and each row has a fixed number of node positions. Every node has two downward edges into the next row. One edge tests the row variable and the other tests its complement. Each edge is programmed to conduct never, always, or only when its literal holds. A single entry node sits at the top, and one detector sits under each position of the bottom row. The function reads true when a conducting path runs from the entry to any detector. A legal program gives exactly one such path, so the block also flags any evaluation in which more than one path conducts.

A parameter vector fixes which side carries the true literal in each row. All zeros gives a uniform orientation, all ones gives the reversed one, and a mix gives a sparse pattern. The variable vector and the configuration are captured on every clock edge. The two flags follow from the captured values. A node count is computed row by row, so that the number of paths reaching every node is known, saturating at two.

Top module: `dlat_fabric`

## Requirements
- R1: After reset, and until the first clock edge at which reset is low, both flags are 0.
- R2: An edge coded 2'b00 or 2'b11 never conducts. With every edge coded this way, both flags are 0 for any variable vector.
- R3: An edge coded 2'b10 conducts for either value of its row variable.
- R4: An edge coded 2'b01 conducts only when its literal holds. In a row whose orientation bit is 0, the left edge (side 0) tests the variable true and the right edge (side 1) tests it false.
- R5: In a row whose orientation bit is 1, the left edge tests the variable false and the right edge tests it true.
- R6: The left edge of node p leads to position p in the row below, and the right edge leads to position p+1. A right edge leaving the last position leads nowhere and contributes to no path.
- R7: func_o is 1 exactly when at least one conducting path links the entry node (position ENTRY of the top row) to a bottom detector.
- R8: multi_o is 1 exactly when two or more conducting paths reach the detectors in total. This includes paths that branch apart and paths that merge back into one node.
- R9: The flags depend only on the inputs sampled at the most recent rising clock edge. A change of input between edges does not move the flags until the next edge.
- The configuration bit of row r, node p and side s starts at index ((r*W+p)*2+s)*2 of cfg_in and is 2 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| x_in | input | ROWS | Variable vector; bit r drives row r |
| cfg_in | input | ROWS*W*4 | Edge codes: 00/11 open, 01 active, 10 short |
| func_o | output | 1 | A conducting path reaches a detector |
| multi_o | output | 1 | Two or more conducting paths reach the detectors |

## Verification
The function flag and the multiple-path flag are produced by the same evaluation, so they can rise in the same cycle. The bench provokes this with programs that split the path into two branches that both reach detectors. It also uses programs that split the path and merge it again into one node above a single detector. These are mixed with random edge codes and variable vectors. Each cycle is judged against a model that counts every path without saturation and derives both flags from that count.

// File: rtl/dlat_pkg.sv
package dlat_pkg;

  typedef enum logic [1:0] {
    EC_OPEN   = 2'b00,
    EC_ACTIVE = 2'b01,
    EC_SHORT  = 2'b10,
    EC_OPEN2  = 2'b11
  } edge_code_e;

  typedef logic [1:0] pcnt_t;

  localparam pcnt_t PCNT_SAT = 2'd2;

  function automatic pcnt_t sat_add(pcnt_t a, pcnt_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd2) return PCNT_SAT;
    return s[1:0];
  endfunction

  // literal seen by an edge on the given side (0 left, 1 right)
  function automatic logic edge_literal(logic var_v, logic mirror, logic side);
    if (side == mirror) return var_v;
    return ~var_v;
  endfunction

  function automatic logic edge_on(logic [1:0] code, logic lit);
    case (edge_code_e'(code))
      EC_ACTIVE: return lit;
      EC_SHORT:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dlat_in_reg.sv
module dlat_in_reg #(
  parameter int ROWS = 4,
  parameter int CFGW = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ROWS-1:0] x_in,
  input  logic [CFGW-1:0] cfg_in,
  output logic [ROWS-1:0] x_q,
  output logic [CFGW-1:0] cfg_q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      x_q   <= '0;
      cfg_q <= '0;
    end else begin
      x_q   <= x_in;
      cfg_q <= cfg_in;
    end
  end

endmodule

// File: rtl/dlat_row.sv
module dlat_row
  import dlat_pkg::*;
#(
  parameter int   W      = 4,
  parameter logic MIRROR = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                var_v,
  input  logic [W*4-1:0]      cfg_row,
  input  logic [W-1:0][1:0]   cnt_in,
  output logic [W-1:0][1:0]   cnt_out
);

  logic lit_left, lit_right;
  assign lit_left  = edge_literal(var_v, MIRROR, 1'b0);
  assign lit_right = edge_literal(var_v, MIRROR, 1'b1);

  logic [W-1:0] row_all_open;

  for (genvar c = 0; c < W; c++) begin : g_child
    pcnt_t from_l, from_r;
    assign from_l = edge_on(cfg_row[c*4 +: 2], lit_left) ? cnt_in[c] : '0;
    if (c > 0) begin : g_has_right
      assign from_r = edge_on(cfg_row[(c-1)*4+2 +: 2], lit_right) ? cnt_in[c-1] : '0;
    end else begin : g_no_right
      assign from_r = '0;
    end
    assign cnt_out[c] = sat_add(from_l, from_r);
    assign row_all_open[c] = (cfg_row[c*4 +: 2] inside {EC_OPEN, EC_OPEN2}) &&
                             (cfg_row[c*4+2 +: 2] inside {EC_OPEN, EC_OPEN2});
  end

  // R7: nothing arrives below a row that received nothing
  p_reach_needs_parent_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_out != '0) |-> (cnt_in != '0));

  // R2: a row of open edges passes no path
  p_open_row_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (&row_all_open) |-> (cnt_out == '0));

endmodule

// File: rtl/dlat_detect.sv
module dlat_detect
  import dlat_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0][1:0] det_cnt,
  output logic              func_o,
  output logic              multi_o
);

  pcnt_t total;
  logic [W-1:0] det_hit;

  always_comb begin
    total = '0;
    for (int c = 0; c < W; c++) total = sat_add(total, det_cnt[c]);
  end

  for (genvar c = 0; c < W; c++) begin : g_hit
    assign det_hit[c] = (det_cnt[c] != '0);
  end

  assign func_o  = (total != '0);
  assign multi_o = (total == PCNT_SAT);

  // R8: a single-path result reaches one detector with a count of one
  p_single_detector_r8: assert property (@(posedge clk) disable iff (rst)
    (func_o && !multi_o) |-> $onehot0(det_hit));

endmodule

// File: rtl/dlat_fabric.sv
module dlat_fabric
  import dlat_pkg::*;
#(
  parameter int              ROWS   = 4,
  parameter int              W      = 4,
  parameter int              ENTRY  = 0,
  parameter logic [ROWS-1:0] ORIENT = 4'b0010
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ROWS-1:0]     x_in,
  input  logic [ROWS*W*4-1:0] cfg_in,
  output logic                func_o,
  output logic                multi_o
);

  localparam int ROWW = W * 4;
  localparam int CFGW = ROWS * ROWW;

  logic [ROWS-1:0] x_q;
  logic [CFGW-1:0] cfg_q;

  dlat_in_reg #(.ROWS(ROWS), .CFGW(CFGW)) u_inreg (
    .clk(clk), .rst(rst), .x_in(x_in), .cfg_in(cfg_in),
    .x_q(x_q), .cfg_q(cfg_q)
  );

  logic [ROWS:0][W-1:0][1:0] stage;

  always_comb begin
    stage[0] = '0;
    stage[0][ENTRY] = 2'd1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    dlat_row #(.W(W), .MIRROR(ORIENT[r])) u_row (
      .clk(clk), .rst(rst),
      .var_v(x_q[r]),
      .cfg_row(cfg_q[r*ROWW +: ROWW]),
      .cnt_in(stage[r]),
      .cnt_out(stage[r+1])
    );
  end

  dlat_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .det_cnt(stage[ROWS]),
    .func_o(func_o), .multi_o(multi_o)
  );

  // R1: flags clear in the first cycle out of reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!func_o && !multi_o));

  // R8: several paths always imply at least one path
  p_multi_implies_func_r8: assert property (@(posedge clk) disable iff (rst)
    multi_o |-> func_o);

  // R9: unchanged sampled inputs leave the flags unchanged
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(x_in) && $stable(cfg_in)) |=> ($stable(func_o) && $stable(multi_o)));

endmodule

// File: tb/sim_dlat_fabric.sv
`timescale 1ns/1ps
module sim_dlat_fabric;

  localparam int ROWS = 4;
  localparam int W = 4;
  localparam int ENTRY = 0;
  localparam logic [ROWS-1:0] ORIENT = 4'b0010;
  localparam int CFGW = ROWS * W * 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROWS-1:0] x_in = '0;
  logic [CFGW-1:0] cfg_in = '0;
  logic func_o, multi_o;

  int checks = 0;
  int fails = 0;
  int exp_paths = 0;

  always #2 clk = ~clk;

  dlat_fabric #(.ROWS(ROWS), .W(W), .ENTRY(ENTRY), .ORIENT(ORIENT)) u0 (
    .clk(clk), .rst(rst), .x_in(x_in), .cfg_in(cfg_in),
    .func_o(func_o), .multi_o(multi_o)
  );

  // behavioural path counter, no saturation
  function automatic int count_paths(logic [ROWS-1:0] xv, logic [CFGW-1:0] cv);
    int cur[W];
    int nxt[W];
    int total;
    foreach (cur[i]) cur[i] = 0;
    cur[ENTRY] = 1;
    for (int r = 0; r < ROWS; r++) begin
      foreach (nxt[i]) nxt[i] = 0;
      for (int p = 0; p < W; p++) begin
        for (int s = 0; s < 2; s++) begin
          logic [1:0] code;
          logic lit;
          bit cond;
          code = cv[((r*W+p)*2+s)*2 +: 2];
          lit = (s == int'(ORIENT[r])) ? xv[r] : ~xv[r];
          cond = (code == 2'b10) || (code == 2'b01 && lit);
          if (cond && (p + s) < W) nxt[p+s] += cur[p];
        end
      end
      cur = nxt;
    end
    total = 0;
    foreach (cur[i]) total += cur[i];
    return total;
  endfunction

  function automatic logic [CFGW-1:0] put(logic [CFGW-1:0] cv, int r, int p, int s, logic [1:0] code);
    logic [CFGW-1:0] o;
    o = cv;
    o[((r*W+p)*2+s)*2 +: 2] = code;
    return o;
  endfunction

  task automatic check_flags(string tag, int n);
    logic ef, em;
    ef = (n > 0);
    em = (n >= 2);
    checks++;
    if (func_o !== ef || multi_o !== em) begin
      fails++;
      $display("FAIL %s: func/multi actual %b/%b expected %b/%b", tag, func_o, multi_o, ef, em);
    end
  endtask

  // drive at a falling edge, judge at the next falling edge
  task automatic apply(logic [ROWS-1:0] xv, logic [CFGW-1:0] cv, string tag);
    int n;
    n = count_paths(xv, cv);
    x_in = xv;
    cfg_in = cv;
    #1;
    check_flags("R9", exp_paths);
    @(posedge clk);
    @(negedge clk);
    exp_paths = n;
    check_flags(tag, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [CFGW-1:0] c;
    repeat (3) @(negedge clk);
    check_flags("R1", 0);
    rst = 1'b0;
    @(negedge clk);
    check_flags("R1", 0);

    // R2: all open, both open codes
    apply(4'hF, '0, "R2");
    apply(4'h5, {CFGW{1'b1}}, "R2");

    // R3: left shorts straight down from position 0
    c = '0;
    for (int r = 0; r < ROWS; r++) c = put(c, r, 0, 0, 2'b10);
    apply(4'h0, c, "R3");
    apply(4'hF, c, "R3");

    // R4: uniform row 0, left edge active tests x[0] true
    c = '0;
    for (int r = 0; r < ROWS; r++) c = put(c, r, 0, 0, (r == 0) ? 2'b01 : 2'b10);
    apply(4'b0001, c, "R4");
    apply(4'b0000, c, "R4");

    // R5: reversed row 1, left edge active tests x[1] false
    c = '0;
    for (int r = 0; r < ROWS; r++) c = put(c, r, 0, 0, (r == 1) ? 2'b01 : 2'b10);
    apply(4'b0000, c, "R5");
    apply(4'b0010, c, "R5");

    // R6: right edge leaving the last position is dropped
    c = '0;
    for (int r = 0; r < ROWS; r++) c = put(c, r, r, 1, 2'b10);
    apply(4'h0, c, "R6");
    c = put(c, 3, 3, 1, 2'b00);
    c = put(c, 3, 3, 0, 2'b10);
    apply(4'h0, c, "R6");

    // R8: split into two detectors
    c = '0;
    c = put(c, 0, 0, 0, 2'b10);
    c = put(c, 0, 0, 1, 2'b10);
    for (int r = 1; r < ROWS; r++) begin
      c = put(c, r, 0, 0, 2'b10);
      c = put(c, r, 1, 0, 2'b10);
    end
    apply(4'h0, c, "R8");

    // R8: split then merge into one node
    c = '0;
    c = put(c, 0, 0, 0, 2'b10);
    c = put(c, 0, 0, 1, 2'b10);
    c = put(c, 1, 0, 1, 2'b10);
    c = put(c, 1, 1, 0, 2'b10);
    c = put(c, 2, 1, 0, 2'b10);
    c = put(c, 3, 1, 0, 2'b10);
    apply(4'h0, c, "R8");

    // R9: hold for a cycle with unchanged inputs
    apply(4'h0, c, "R9");

    // R7/R8 random programs
    for (int k = 0; k < 400; k++) begin
      logic [CFGW-1:0] rc;
      for (int b = 0; b < CFGW / 2; b++) rc[b*2 +: 2] = 2'($urandom % 4);
      apply(ROWS'($urandom), rc, (k % 2 == 0) ? "R7" : "R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule